// File: doc/BRIEF.md
# Genlock Data Nibble Inserter

This block sits on the 8-bit digitized video path and carries the recovered genlock data (subcarrier frequency, subcarrier phase and field identity) on that path to downstream decoders and encoders. While the horizontal sync tip window is open, it replaces the low four bits of the video bus with the payload, one 4-bit nibble per pixel clock. The upper four bits keep the video samples. Outside the window, the whole bus carries video unchanged.

The payload is captured once, on the first pixel clock of each sync tip, so that a burst never mixes old and new loop values. When the video-present flag is low at that moment, the frequency and phase fields are taken from a built-in default set chosen by a 2-bit format selector. The sync-tip bursts carry on during the loss of video. When video comes back, the next burst carries live loop values again. This is well within the two-frame relock window.

Top module: `genlock_nibble_mux`

## Requirements
- R1: While `rst` is high at a clock edge, `bus_out` becomes 8'h00 after that edge.
- R2: When `sync_tip` is low at an edge, `bus_out` equals the `video_in` sampled at that edge, from the edge onward.
- R3: When `sync_tip` is high at an edge, `bus_out[7:4]` equals the `video_in[7:4]` sampled at that edge.
- R4: The payload word is 36 bits wide. It is {field_id[3:0], phase[7:0], freq[23:0]}, with freq in bits 23..0. On the k-th consecutive high cycle of `sync_tip` (k = 0..8), `bus_out[3:0]` after that edge carries payload bits 4k+3..4k. Nibbles go least significant first.
- R5: The payload is captured at the edge that opens a sync tip (`sync_tip` high, low at the previous edge or just after reset). Changes to `loop_freq`, `loop_phase`, `field_id`, `video_ok` or `fmt_sel` later in the same tip do not alter that burst.
- R6: Once all 9 nibbles have gone out, the remaining high cycles of `sync_tip` pass `video_in` through unchanged on all 8 bits.
- R7: A sync tip shorter than 9 cycles truncates the burst, and the next tip starts again at nibble 0. A tip still high when reset is released counts as a new tip.
- R8: If `video_ok` is low when a tip opens, the burst's frequency and phase fields take the defaults for `fmt_sel`: 0 gives 24'h21F07C / 8'h00, 1 gives 24'h2A098B / 8'h20, 2 gives 24'h21F694 / 8'h40 and 3 gives 24'h21E6EF / 8'h60. The field ID stays live.
- R9: The first tip that opens with `video_ok` high after a period without video carries the live loop values.
- R10: `fmt_sel` has no effect on a burst that opens with `video_ok` high.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_tip | input | 1 | High during the horizontal sync tip window |
| video_ok | input | 1 | Input video is present |
| fmt_sel | input | 2 | Video format selector for fallback defaults |
| loop_freq | input | 24 | Subcarrier frequency word from the loop |
| loop_phase | input | 8 | Subcarrier phase word from the loop |
| field_id | input | 4 | Current field identifier |
| video_in | input | 8 | Digitized video samples |
| bus_out | output | 8 | Video bus with genlock nibbles inserted |

## Verification
Every result is due one clock after the edge that samples its inputs, since the only register between input and `bus_out` is the output stage. The bench drives inputs on the falling edge and reads `bus_out` one time unit after the next rising edge. It compares against the nibble picked by the tip-cycle count k that the bench keeps itself. The expected payload is fixed before the tip opens, and the loop inputs are then changed three cycles in. That tests the capture-once rule at the exact cycle that matters. After the burst, four gap cycles test the pass-through path.

// File: rtl/gnm_pkg.sv
package gnm_pkg;

    localparam int FREQ_W  = 24;
    localparam int PHASE_W = 8;
    localparam int FID_W   = 4;
    localparam int NIB_W   = 4;
    localparam int VID_W   = 8;
    localparam int FMT_W   = 2;

    localparam int PAY_W   = FREQ_W + PHASE_W + FID_W;
    localparam int NIB_N   = (PAY_W + NIB_W - 1) / NIB_W;
    localparam int IDX_W   = $clog2(NIB_N + 1);
    localparam int WIDE_W  = NIB_N * NIB_W;

    // Field order sets the nibble order on the bus: freq first, fid last.
    typedef struct packed {
        logic [FID_W-1:0]   fid;
        logic [PHASE_W-1:0] phase;
        logic [FREQ_W-1:0]  freq;
    } payload_t;

    function automatic logic [FREQ_W-1:0] fallback_freq(input logic [FMT_W-1:0] fmt);
        logic [FREQ_W-1:0] r;
        case (fmt)
            2'd0:    r = 24'h21F07C;
            2'd1:    r = 24'h2A098B;
            2'd2:    r = 24'h21F694;
            default: r = 24'h21E6EF;
        endcase
        return r;
    endfunction

    function automatic logic [PHASE_W-1:0] fallback_phase(input logic [FMT_W-1:0] fmt);
        return PHASE_W'({fmt, 5'b00000});
    endfunction

    function automatic logic [NIB_W-1:0] pick_nibble(input payload_t p,
                                                     input logic [IDX_W-1:0] k);
        logic [WIDE_W-1:0] wide;
        wide = WIDE_W'(p);
        return wide[k*NIB_W +: NIB_W];
    endfunction

endpackage

// File: rtl/gnm_src_select.sv
module gnm_src_select
    import gnm_pkg::*;
(
    input  logic                video_ok,
    input  logic [FMT_W-1:0]    fmt_sel,
    input  logic [FREQ_W-1:0]   loop_freq,
    input  logic [PHASE_W-1:0]  loop_phase,
    input  logic [FID_W-1:0]    field_id,
    output payload_t            src
);
    always_comb begin
        src.fid = field_id;
        if (video_ok) begin
            src.freq  = loop_freq;
            src.phase = loop_phase;
        end else begin
            src.freq  = fallback_freq(fmt_sel);
            src.phase = fallback_phase(fmt_sel);
        end
    end
endmodule

// File: rtl/gnm_burst_ctl.sv
module gnm_burst_ctl
    import gnm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_tip,
    output logic             tip_open,
    output logic             send,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] idx_q
);
    localparam logic [IDX_W-1:0] IDLE = IDX_W'(NIB_N);

    logic tip_d;

    assign tip_open = sync_tip && !tip_d;
    assign cur_idx  = tip_open ? '0 : idx_q;
    assign send     = sync_tip && (tip_open || (idx_q < IDLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            tip_d <= 1'b0;
            idx_q <= IDLE;
        end else begin
            tip_d <= sync_tip;
            if (!sync_tip)
                idx_q <= IDLE;
            else if (tip_open)
                idx_q <= IDX_W'(1);
            else if (idx_q < IDLE)
                idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/gnm_payload_hold.sv
module gnm_payload_hold
    import gnm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  payload_t d,
    output payload_t view,
    output payload_t held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (load)
            held <= d;
    end

    // The opening cycle uses the fresh value, later cycles the captured one.
    assign view = load ? d : held;
endmodule

// File: rtl/genlock_nibble_mux.sv
module genlock_nibble_mux
    import gnm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sync_tip,
    input  logic                video_ok,
    input  logic [FMT_W-1:0]    fmt_sel,
    input  logic [FREQ_W-1:0]   loop_freq,
    input  logic [PHASE_W-1:0]  loop_phase,
    input  logic [FID_W-1:0]    field_id,
    input  logic [VID_W-1:0]    video_in,
    output logic [VID_W-1:0]    bus_out
);
    payload_t         src_pl;
    payload_t         view_pl;
    payload_t         held_pl;
    logic             tip_open;
    logic             send;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] burst_idx;
    logic [NIB_W-1:0] nib;
    logic [VID_W-1:0] bus_q;

    gnm_src_select u_src (
        .video_ok   (video_ok),
        .fmt_sel    (fmt_sel),
        .loop_freq  (loop_freq),
        .loop_phase (loop_phase),
        .field_id   (field_id),
        .src        (src_pl)
    );

    gnm_burst_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .sync_tip (sync_tip),
        .tip_open (tip_open),
        .send     (send),
        .cur_idx  (cur_idx),
        .idx_q    (burst_idx)
    );

    gnm_payload_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (tip_open),
        .d    (src_pl),
        .view (view_pl),
        .held (held_pl)
    );

    assign nib = pick_nibble(view_pl, cur_idx);

    always_ff @(posedge clk) begin
        if (rst)
            bus_q <= '0;
        else if (send)
            bus_q <= {video_in[VID_W-1:NIB_W], nib};
        else
            bus_q <= video_in;
    end

    assign bus_out = bus_q;
endmodule

// File: rtl/gnm_checker.sv
module gnm_checker
    import gnm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sync_tip,
    input logic [VID_W-1:0] video_in,
    input logic [VID_W-1:0] bus_out,
    input logic [IDX_W-1:0] burst_idx,
    input payload_t         held_pl
);
    logic tip_prev;

    always_ff @(posedge clk) begin
        if (rst) tip_prev <= 1'b0;
        else     tip_prev <= sync_tip;
    end

    a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
        !sync_tip |=> bus_out == $past(video_in));

    a_r3_upper_video: assert property (@(posedge clk) disable iff (rst)
        sync_tip |=> bus_out[VID_W-1:NIB_W] == $past(video_in[VID_W-1:NIB_W]));

    a_r5_payload_frozen: assert property (@(posedge clk) disable iff (rst)
        (sync_tip && tip_prev) |=> $stable(held_pl));

    a_r6_idx_bounded: assert property (@(posedge clk) disable iff (rst)
        burst_idx <= IDX_W'(NIB_N));

    a_r6_done_passes: assert property (@(posedge clk) disable iff (rst)
        (sync_tip && tip_prev && burst_idx == IDX_W'(NIB_N)) |=> bus_out == $past(video_in));

    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        (sync_tip && !tip_prev) |=> burst_idx == IDX_W'(1));
endmodule

bind genlock_nibble_mux gnm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_tip  (sync_tip),
    .video_in  (video_in),
    .bus_out   (bus_out),
    .burst_idx (burst_idx),
    .held_pl   (held_pl)
);

// File: tb/sim_genlock_nibble_mux.sv
module sim_genlock_nibble_mux;
    logic        clk = 1'b0;
    logic        rst;
    logic        sync_tip;
    logic        video_ok;
    logic [1:0]  fmt_sel;
    logic [23:0] loop_freq;
    logic [7:0]  loop_phase;
    logic [3:0]  field_id;
    logic [7:0]  video_in;
    logic [7:0]  bus_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    genlock_nibble_mux u0 (
        .clk(clk), .rst(rst), .sync_tip(sync_tip), .video_ok(video_ok),
        .fmt_sel(fmt_sel), .loop_freq(loop_freq), .loop_phase(loop_phase),
        .field_id(field_id), .video_in(video_in), .bus_out(bus_out)
    );

    // entry: {video_ok, fmt, freq, phase, fid, tip length, tag code}
    localparam int NV = 8;
    localparam logic [47:0] VEC [NV] = '{
        {1'b1, 2'd0, 24'h123456, 8'h9A, 4'hB, 5'd12, 4'd4},
        {1'b1, 2'd3, 24'hFEDCBA, 8'h10, 4'h2, 5'd9,  4'd10},
        {1'b0, 2'd0, 24'h777777, 8'h77, 4'h5, 5'd12, 4'd8},
        {1'b0, 2'd1, 24'h111111, 8'h22, 4'hC, 5'd10, 4'd8},
        {1'b0, 2'd2, 24'h333333, 8'h44, 4'h1, 5'd12, 4'd8},
        {1'b0, 2'd3, 24'h555555, 8'h66, 4'h9, 5'd11, 4'd8},
        {1'b1, 2'd2, 24'hA5A5A5, 8'h5A, 4'hF, 5'd5,  4'd9},
        {1'b1, 2'd1, 24'h0F0F0F, 8'hF0, 4'h7, 5'd14, 4'd7}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] dflt_freq(input logic [1:0] f);
        case (f)
            2'd0:    return 24'h21F07C;
            2'd1:    return 24'h2A098B;
            2'd2:    return 24'h21F694;
            default: return 24'h21E6EF;
        endcase
    endfunction

    function automatic logic [7:0] dflt_phase(input logic [1:0] f);
        case (f)
            2'd0:    return 8'h00;
            2'd1:    return 8'h20;
            2'd2:    return 8'h40;
            default: return 8'h60;
        endcase
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            7:       return "R7";
            8:       return "R8";
            9:       return "R9";
            10:      return "R10";
            default: return "R4";
        endcase
    endfunction

    task automatic run_tip(input int len, input logic [35:0] pay, input int seed, input string tag);
        for (int c = 0; c < len; c++) begin
            logic [7:0] exp;
            string      lbl;
            @(negedge clk);
            sync_tip = 1'b1;
            video_in = 8'(seed * 17 + c * 29 + 3);
            if (c == 3) begin
                loop_freq  = ~loop_freq;
                loop_phase = ~loop_phase;
                field_id   = ~field_id;
                fmt_sel    = fmt_sel + 2'd1;
                video_ok   = ~video_ok;
            end
            if (c < 9) begin
                exp = {video_in[7:4], pay[4*c +: 4]};
                lbl = (c >= 3) ? {tag, " R5 R3"} : {tag, " R3"};
            end else begin
                exp = video_in;
                lbl = "R6";
            end
            @(posedge clk); #1;
            chk(lbl, bus_out, exp);
        end
        for (int g = 0; g < 4; g++) begin
            logic [7:0] v;
            @(negedge clk);
            sync_tip = 1'b0;
            video_in = 8'(seed * 5 + g * 41 + 9);
            v = video_in;
            @(posedge clk); #1;
            chk("R2", bus_out, v);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        sync_tip   = 1'b0;
        video_ok   = 1'b1;
        fmt_sel    = 2'd0;
        loop_freq  = '0;
        loop_phase = '0;
        field_id   = '0;
        video_in   = 8'hA7;
        repeat (3) @(posedge clk);
        #1 chk("R1 reset", bus_out, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [35:0] pay;
            logic        ok;
            logic [1:0]  f;
            @(negedge clk);
            ok         = VEC[i][47];
            f          = VEC[i][46:45];
            video_ok   = ok;
            fmt_sel    = f;
            loop_freq  = VEC[i][44:21];
            loop_phase = VEC[i][20:13];
            field_id   = VEC[i][12:9];
            pay = {VEC[i][12:9],
                   ok ? VEC[i][20:13] : dflt_phase(f),
                   ok ? VEC[i][44:21] : dflt_freq(f)};
            run_tip(int'(VEC[i][8:4]), pay, i + 1, tag_of(int'(VEC[i][3:0])));
        end

        // Directed: reset during a burst, then a tip still open after release (R1, R7)
        @(negedge clk);
        video_ok   = 1'b1;
        loop_freq  = 24'hC0FFEE;
        loop_phase = 8'h3D;
        field_id   = 4'h6;
        sync_tip   = 1'b1;
        video_in   = 8'h5C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 mid-burst", bus_out, 8'h00);
        @(negedge clk);
        rst      = 1'b0;
        video_in = 8'h91;
        @(posedge clk); #1;
        chk("R7 reopen", bus_out, {4'h9, 4'hE});
        @(negedge clk);
        video_in = 8'h42;
        @(posedge clk); #1;
        chk("R7 second", bus_out, {4'h4, 4'hE});
        @(negedge clk);
        sync_tip = 1'b0;
        video_in = 8'h3B;
        @(posedge clk); #1;
        chk("R2 close", bus_out, 8'h3B);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule